// File: doc/BRIEF.md
# Serial Memory Two-Wire Slave Front End

This block is the bus-facing half of a byte-addressed serial memory. It watches the SCL and SDA lines of a two-wire (I2C) bus through two-flop synchronizers on a system clock at least 16 times faster than SCL. It finds start and stop conditions and compares the device address byte with its own fixed address. For writes it takes a two-byte memory address and then hands each data byte to an external page buffer. For reads it fetches bytes from memory and shifts them out. The slave pulls SDA low by raising an open-drain output enable. It never drives the line high.

The write path reports each accepted data byte as a one-cycle strobe with its address. It gives a commit strobe when the stop condition ends a write, so the memory can start its internal write cycle. While that cycle runs, the memory raises a busy input. The slave then refuses its address, so a master can poll with repeated address bytes until the slave acknowledges. A read with no address phase returns data from the current internal address. A selective read loads an address and then turns the bus round with a repeated start. A sequential read goes on for as long as the master acknowledges.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends any command, returns the slave to idle with SDA released, and, if at least one data byte was written since the start, pulses `wr_commit` for one cycle. After reset `sda_oe`, `wr_en` and `wr_commit` are 0.
- R2: The slave answers a device byte whose upper seven bits are 1010 followed by parameter `DEV_SEL` (default 000). Bit 0 selects the direction, where 1 is read. Any other device byte is left unacknowledged, and the slave ignores the bus with SDA released until the next start.
- R3: The slave acknowledges by pulling SDA low from the falling SCL edge after the 8th bit until the falling edge after the 9th. It never starts pulling SDA low while SCL is high.
- R4: While `wr_busy` is 1, the slave does not acknowledge its own device byte.
- R5: In a write, the device byte is followed by the high address byte, then the low address byte, then data bytes, and each of them is acknowledged. Address bits above `AW` are ignored. Each data byte gives a one-cycle `wr_en` with `wr_addr` and `wr_data`.
- R6: Across data bytes of one write, the low log2(`PAGE_BYTES`) address bits count up and wrap within the page, and the upper bits stay fixed.
- R7: A read with no address phase returns the byte at the internal address. After a read byte has been sent, that address points one past it.
- R8: A selective read (write device byte, two address bytes, repeated start, read device byte) returns the byte at the loaded address.
- R9: After a read byte, a master ACK makes the slave send the next byte, and the address wraps from the last location to 0. A master NACK ends the transfer with SDA released.
- R10: Bytes travel MSB first. Input bits are sampled on SCL rising, and the slave changes its output bit only after SCL falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| wr_busy | input | 1 | Memory internal write cycle in progress |
| rd_data | input | 8 | Memory byte at `rd_addr` (combinational) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_en | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | AW | Address of the received data byte |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle strobe at a stop that ends a write |
| rd_addr | output | AW | Current internal memory address |

## Verification
Every response of the slave comes from an SCL or SDA edge that passes through two synchronizing flops and one edge-detect flop. As a result, `sda_oe`, `wr_en` and the address updates change about four system cycles after the bus edge that causes them, and `wr_commit` comes the same delay after the SDA rise of a stop. The bench holds each SCL phase for 20 cycles. It reads the slave's acknowledge and data bits 10 cycles into the high phase, long after the slave has settled and well before the next edge. It checks the write log and the commit count only after the stop sequence has finished.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int AW = 12,
  parameter int PAGE_BYTES = 32,
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          wr_busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic [AW-1:0] rd_addr
);

  localparam int PW = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD} st_t;

  st_t           state;
  logic [2:0]    scl_sy, sda_sy;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, addr_hi;
  logic [AW-1:0] cur_addr;
  logic          rw, mack, pending;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  wire scl_s = scl_sy[1];
  wire scl_q = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_q = sda_sy[2];

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & ~sda_s & sda_q;
  wire stop_det  = scl_s & scl_q & sda_s & ~sda_q;

  wire dev_hit = (sh[7:1] == {4'b1010, DEV_SEL}) && !wr_busy;
  wire [AW-1:0] page_next = {cur_addr[AW-1:PW], cur_addr[PW-1:0] + PW'(1)};

  assign rd_addr = cur_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      addr_hi   <= '0;
      cur_addr  <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      pending   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      wr_commit <= 1'b0;
      if (start_det) begin
        state   <= ST_DEV;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        pending <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        pending <= 1'b0;
        if (pending) wr_commit <= 1'b1;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8 && state != ST_RD) sh <= {sh[6:0], sda_s};
          if (bitcnt == 4'd8) mack <= ~sda_s;
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (state == ST_RD) begin
            if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end else if (bitcnt == 4'd8) begin
              sda_oe   <= 1'b0;
              cur_addr <= cur_addr + AW'(1);
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end else if (bitcnt == 4'd8) begin
            case (state)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI: begin
                addr_hi <= sh;
                sda_oe  <= 1'b1;
              end
              ST_ALO: begin
                cur_addr <= AW'({addr_hi, sh});
                sda_oe   <= 1'b1;
              end
              default: begin
                wr_en    <= 1'b1;
                wr_addr  <= cur_addr;
                wr_data  <= sh;
                cur_addr <= page_next;
                pending  <= 1'b1;
                sda_oe   <= 1'b1;
              end
            endcase
          end else if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            case (state)
              ST_DEV: begin
                if (rw) begin
                  state  <= ST_RD;
                  sh     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:  state <= ST_ALO;
              default: state <= ST_WR;
            endcase
          end
        end
      end
    end

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s)); // R3
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(state) == ST_DEV && $past(bitcnt) == 4'd8) |-> !$past(wr_busy)); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R5
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det)); // R1

endmodule

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
  localparam int AW = 12;
  localparam logic [7:0] DEVW = 8'hA0;
  localparam logic [7:0] DEVR = 8'hA1;
  localparam logic [23:0] VEC [6] = '{24'h00003C, 24'h012381, 24'hF4567E,
                                      24'h0FFFA5, 24'h080000, 24'h07C0FF};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic wr_en, wr_commit, sda_oe;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [1 << AW];
  logic [AW-1:0] lg_a [8];
  logic [7:0] lg_d [8];
  int lg_n = 0, cmt_n = 0, busy_cnt = 0, cyc = 0, checks = 0, errors = 0;

  wire sda_bus = msda & ~sda_oe;
  wire wr_busy = busy_cnt != 0;
  assign rd_data = mem[rd_addr];

  always #5 clk = ~clk;

  eeprom_i2c_slave #(.AW(AW), .PAGE_BYTES(32), .DEV_SEL(3'b000)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .wr_busy(wr_busy),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_en) begin
      lg_a[lg_n % 8] <= wr_addr;
      lg_d[lg_n % 8] <= wr_data;
      mem[wr_addr] <= wr_data;
      lg_n <= lg_n + 1;
    end
    if (wr_commit) begin
      cmt_n <= cmt_n + 1;
      busy_cnt <= 1000;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (cyc == 180000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<180000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic m_start;
    msda = 1'b1; wcyc(5); scl = 1'b1; wcyc(20);
    msda = 1'b0; wcyc(20); scl = 1'b0;
  endtask

  task automatic m_stop;
    msda = 1'b0; wcyc(15); scl = 1'b1; wcyc(20); msda = 1'b1; wcyc(20);
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wcyc(5); msda = b[i]; wcyc(15); scl = 1'b1; wcyc(20); scl = 1'b0;
    end
    wcyc(5); msda = 1'b1; wcyc(15); scl = 1'b1; wcyc(10);
    ack = ~sda_bus; wcyc(10); scl = 1'b0;
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wcyc(5); msda = 1'b1; wcyc(15); scl = 1'b1; wcyc(10);
      b[i] = sda_bus; wcyc(10); scl = 1'b0;
    end
    wcyc(5); msda = ~give_ack; wcyc(15); scl = 1'b1; wcyc(20); scl = 1'b0;
  endtask

  task automatic open_write(input logic [15:0] a, output int nacks);
    logic ack;
    nacks = 0;
    for (int k = 0; k < 60; k++) begin
      m_start; m_send(DEVW, ack);
      if (ack) break;
      nacks = nacks + 1;
      m_stop; wcyc(40);
    end
    m_send(a[15:8], ack); chk("R5 high address ack", ack, 1'b1);
    m_send(a[7:0], ack);  chk("R5 low address ack", ack, 1'b1);
  endtask

  task automatic sel_read(input logic [15:0] a, output logic [7:0] b, output int nacks);
    logic ack;
    open_write(a, nacks);
    m_start; m_send(DEVR, ack); chk("R8 read device ack", ack, 1'b1);
    m_recv(1'b0, b); m_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] b, b0, b1, b2;
    int n, base;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'(i >> 4) ^ 8'h5A;
    wcyc(3);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    chk("R1 reset wr_en", wr_en, 1'b0);
    chk("R1 reset wr_commit", wr_commit, 1'b0);
    rst_n = 1'b1; wcyc(5);

    for (int v = 0; v < 6; v++) begin
      base = lg_n;
      n = cmt_n;
      open_write(VEC[v][23:8], ack ? n : n);
      n = cmt_n;
      m_send(VEC[v][7:0], ack); chk("R5 data ack", ack, 1'b1);
      m_stop; wcyc(5);
      chk("R5 wr_addr", lg_a[base % 8], 32'(VEC[v][19:8]));
      chk("R10 wr_data msb first", lg_d[base % 8], 32'(VEC[v][7:0]));
      chk("R1 commit at stop", cmt_n, n + 1);
      sel_read(VEC[v][23:8], b, n);
      chk("R4 polled while busy", n > 0, 1'b1);
      chk("R8 selective read data", b, 32'(VEC[v][7:0]));
    end

    m_start; m_send(8'hA8, ack); chk("R2 foreign address nack", ack, 1'b0);
    m_send(8'hA0, ack); chk("R2 ignored until start", ack, 1'b0);
    chk("R2 released while ignoring", sda_oe, 1'b0);
    m_stop;

    open_write(16'h0FFE, n);
    m_start; m_send(DEVR, ack); chk("R9 read device ack", ack, 1'b1);
    m_recv(1'b1, b0); m_recv(1'b1, b1); m_recv(1'b0, b2);
    wcyc(10);
    chk("R9 released after nack", sda_oe, 1'b0);
    m_stop;
    chk("R9 seq byte ffe", b0, mem[12'hFFE]);
    chk("R9 seq byte fff", b1, mem[12'hFFF]);
    chk("R9 seq wrap to 000", b2, mem[12'h000]);

    m_start; m_send(DEVR, ack); chk("R7 current read ack", ack, 1'b1);
    m_recv(1'b0, b); m_stop;
    chk("R7 current address data", b, mem[12'h001]);

    base = lg_n;
    open_write(16'h001E, n);
    m_send(8'h11, ack); m_send(8'h22, ack); m_send(8'h33, ack); m_send(8'h44, ack);
    chk("R3 last data ack", ack, 1'b1);
    m_stop; wcyc(5);
    chk("R6 page byte 0", lg_a[base % 8], 32'h01E);
    chk("R6 page byte 1", lg_a[(base + 1) % 8], 32'h01F);
    chk("R6 page wrap 2", lg_a[(base + 2) % 8], 32'h000);
    chk("R6 page wrap 3", lg_a[(base + 3) % 8], 32'h001);
    m_start; m_send(DEVW, ack); chk("R4 busy nack", ack, 1'b0);
    m_stop;
    chk("R1 idle after stop", sda_oe, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule